// File: doc/BRIEF.md
# Predicated Dual-Bank Register File

This block holds the architectural registers of a two-sided datapath. There are two banks, side A and side B, and each has sixteen 32-bit registers. Each bank offers two asynchronous read ports. A single write channel reaches either bank. A write commits only when its predicate passes. The predicate is the zero or nonzero state of one of five fixed registers, and it can be inverted.

The write channel has four modes. The first is a plain 32-bit write. The second is a 40-bit write into an even:odd register pair on one side. The remaining two load a 16-bit constant: the low-half load sign-extends and replaces the whole register, and the high-half load replaces only the upper half. To build a full 32-bit constant, issue the low load first and the high load second. Every read port also presents the 40-bit pair that starts at its index, sign-extended to 64 bits.

Top module: `rf_two_side`

## Requirements
- R1: While rst_ni is low, every register on both sides is cleared to zero.
- R2: A register specifier is 5 bits. Bit 4 selects the side (0 = A, 1 = B) and bits 3:0 select the register. Mode 0 writes wr_data_i[31:0] to the register named by wr_dst_i.
- R3: pred_sel_i selects the write predicate. Code 0 is always true and ignores pred_inv_i. Codes 1 to 5 select A1, A2, B0, B1 and B2, and the predicate is true when that register is nonzero, or when it is zero if pred_inv_i is set. Codes 6 and 7 never allow a write.
- R4: The predicate uses register contents from before the edge at which the write commits, including when the write targets the predicate register itself.
- R5: Mode 1 writes a pair. wr_data_i[31:0] goes to the even register wr_dst_i, and {24'b0, wr_data_i[39:32]} goes to the odd register wr_dst_hi_i.
- R6: A mode 1 request is illegal when the two specifiers name different sides, when the first index is odd, or when the second index is not the first plus one. An illegal request raises wr_err_o in the same cycle, whatever the predicate, and no register changes.
- R7: Mode 2 writes the 16-bit constant, sign-extended to 32 bits, over the whole register.
- R8: Mode 3 replaces bits 31:16 with the constant and keeps bits 15:0.
- R9: Reads are combinational from the stored state. A written value appears after the commit edge, and reads during the write cycle return the old value.
- R10: Read ports 0 and 1 read side A, and ports 2 and 3 read side B. For an even index, rd_pair_o is {odd[7:0], even} sign-extended from bit 39 to 64 bits. For an odd index, rd_pair_o is zero.
- R11: When wr_en_i is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 4x4 | Register index per read port (ports 0-1 side A, 2-3 side B) |
| rd_data_o | output | 4x32 | Register value per read port |
| rd_pair_o | output | 4x64 | Sign-extended 40-bit pair per read port |
| wr_en_i | input | 1 | Write request |
| wr_mode_i | input | 2 | 0 word, 1 pair, 2 constant low, 3 constant high |
| wr_dst_i | input | 5 | Destination specifier (even register for a pair) |
| wr_dst_hi_i | input | 5 | Odd register specifier for a pair |
| wr_data_i | input | 40 | Write data |
| wr_const_i | input | 16 | Constant for modes 2 and 3 |
| pred_sel_i | input | 3 | Predicate register select |
| pred_inv_i | input | 1 | Invert the predicate |
| wr_err_o | output | 1 | Illegal pair request |

## Verification
The assertions assume that the predicate and the constant-high merge both see the stored register values, with no forwarding. They also assume that wr_dst_hi_i matters only in pair mode. The stimulus changes every input at the falling edge and holds it through the next rising edge. It drops wr_en_i after each commit, so every write is a single isolated request. Illegal pair requests are driven with predicate code 0, so any register change can only come from missing error gating.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    WM_WORD = 2'd0,
    WM_PAIR = 2'd1,
    WM_CLO  = 2'd2,
    WM_CHI  = 2'd3
  } wr_mode_e;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int XW   = 8,
  parameter int RPB  = 2,
  localparam int IW  = $clog2(NREG),
  localparam int PW  = DW + XW,
  localparam int HW  = DW / 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_lo_i,
  input  logic [IW-1:0]            idx_lo_i,
  input  logic [DW-1:0]            d_lo_i,
  input  logic                     we_hi_i,
  input  logic [IW-1:0]            idx_hi_i,
  input  logic [DW-1:0]            d_hi_i,
  input  logic [RPB-1:0][IW-1:0]   rd_idx_i,
  output logic [RPB-1:0][DW-1:0]   rd_data_o,
  output logic [RPB-1:0][2*DW-1:0] rd_pair_o,
  output logic [HW-1:0]            cur_lo_o,
  output logic [2:0]               nz_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[r] <= '0;
      else if (we_lo_i && idx_lo_i == IW'(r))       regs_q[r] <= d_lo_i;
      else if (we_hi_i && idx_hi_i == IW'(r))       regs_q[r] <= d_hi_i;
    end
  end

  for (genvar p = 0; p < RPB; p++) begin : g_rd
    logic [PW-1:0] pv;
    assign pv           = {regs_q[{rd_idx_i[p][IW-1:1], 1'b1}][XW-1:0], regs_q[rd_idx_i[p]]};
    assign rd_data_o[p] = regs_q[rd_idx_i[p]];
    assign rd_pair_o[p] = rd_idx_i[p][0] ? '0 : {{(2*DW-PW){pv[PW-1]}}, pv};
  end

  assign cur_lo_o = regs_q[idx_lo_i][HW-1:0];
  for (genvar k = 0; k < 3; k++) begin : g_nz
    assign nz_o[k] = |regs_q[k];
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_lo_i && !we_hi_i) |=> $stable(regs_q));
  a_r5_hi_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hi_i |-> (d_hi_i[DW-1:XW] == '0));
  a_r5_pair_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hi_i |-> (we_lo_i && !idx_lo_i[0] && idx_hi_i == (idx_lo_i | IW'(1))));
endmodule

// File: rtl/rf_pred.sv
module rf_pred (
  input  logic [5:0] nz_i,   // {B2,B1,B0,A2,A1,A0} nonzero flags
  input  logic [2:0] sel_i,
  input  logic       inv_i,
  output logic       ok_o
);
  logic [2:0] src;
  logic       valid;

  always_comb begin
    valid = 1'b1;
    unique case (sel_i)
      3'd1:    src = 3'd1;
      3'd2:    src = 3'd2;
      3'd3:    src = 3'd3;
      3'd4:    src = 3'd4;
      3'd5:    src = 3'd5;
      default: begin src = 3'd0; valid = 1'b0; end
    endcase
  end

  assign ok_o = (sel_i == 3'd0) ? 1'b1 : (valid && (nz_i[src] ^ inv_i));
endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import rf_pkg::*;
#(
  parameter int DW  = 32,
  parameter int XW  = 8,
  parameter int IW  = 4,
  parameter int CW  = 16,
  localparam int PW = DW + XW,
  localparam int SW = IW + 1
) (
  input  logic          en_i,
  input  wr_mode_e      mode_i,
  input  logic [SW-1:0] dst_i,
  input  logic [SW-1:0] dst_hi_i,
  input  logic [PW-1:0] data_i,
  input  logic [CW-1:0] cst_i,
  input  logic [CW-1:0] cur_lo_i,
  input  logic          pred_ok_i,
  output logic [1:0]    we_lo_o,
  output logic [1:0]    we_hi_o,
  output logic [DW-1:0] d_lo_o,
  output logic [DW-1:0] d_hi_o,
  output logic          err_o
);
  logic pair_ok, commit;

  assign pair_ok = (dst_i[IW] == dst_hi_i[IW]) && !dst_i[0] &&
                   (dst_hi_i[IW-1:0] == {dst_i[IW-1:1], 1'b1});
  assign err_o   = en_i && (mode_i == WM_PAIR) && !pair_ok;
  assign commit  = en_i && pred_ok_i && !err_o;

  always_comb begin
    we_lo_o = '0;
    we_hi_o = '0;
    we_lo_o[dst_i[IW]] = commit;
    we_hi_o[dst_i[IW]] = commit && (mode_i == WM_PAIR);
    d_hi_o  = {{(DW-XW){1'b0}}, data_i[PW-1:DW]};
    unique case (mode_i)
      WM_CLO:  d_lo_o = {{(DW-CW){cst_i[CW-1]}}, cst_i};
      WM_CHI:  d_lo_o = {cst_i, cur_lo_i};
      default: d_lo_o = data_i[DW-1:0];
    endcase
  end
endmodule

// File: rtl/rf_two_side.sv
module rf_two_side
  import rf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int XW   = 8,
  parameter int RPB  = 2,
  parameter int CW   = 16,
  localparam int IW  = $clog2(NREG),
  localparam int SW  = IW + 1,
  localparam int NRP = 2 * RPB,
  localparam int PW  = DW + XW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRP-1:0][IW-1:0]   rd_idx_i,
  output logic [NRP-1:0][DW-1:0]   rd_data_o,
  output logic [NRP-1:0][2*DW-1:0] rd_pair_o,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_mode_i,
  input  logic [SW-1:0]            wr_dst_i,
  input  logic [SW-1:0]            wr_dst_hi_i,
  input  logic [PW-1:0]            wr_data_i,
  input  logic [CW-1:0]            wr_const_i,
  input  logic [2:0]               pred_sel_i,
  input  logic                     pred_inv_i,
  output logic                     wr_err_o
);
  wr_mode_e          mode;
  logic [1:0]        we_lo, we_hi;
  logic [DW-1:0]     d_lo, d_hi;
  logic [1:0][CW-1:0] cur_lo;
  logic [1:0][2:0]   nz;
  logic              pred_ok;

  assign mode = wr_mode_e'(wr_mode_i);

  for (genvar s = 0; s < 2; s++) begin : g_side
    rf_bank #(.NREG(NREG), .DW(DW), .XW(XW), .RPB(RPB)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_lo_i   (we_lo[s]),
      .idx_lo_i  (wr_dst_i[IW-1:0]),
      .d_lo_i    (d_lo),
      .we_hi_i   (we_hi[s]),
      .idx_hi_i  (wr_dst_hi_i[IW-1:0]),
      .d_hi_i    (d_hi),
      .rd_idx_i  (rd_idx_i[s*RPB +: RPB]),
      .rd_data_o (rd_data_o[s*RPB +: RPB]),
      .rd_pair_o (rd_pair_o[s*RPB +: RPB]),
      .cur_lo_o  (cur_lo[s]),
      .nz_o      (nz[s])
    );
  end

  rf_pred u_pred (
    .nz_i  ({nz[1], nz[0]}),
    .sel_i (pred_sel_i),
    .inv_i (pred_inv_i),
    .ok_o  (pred_ok)
  );

  rf_wr_decode #(.DW(DW), .XW(XW), .IW(IW), .CW(CW)) u_dec (
    .en_i      (wr_en_i),
    .mode_i    (mode),
    .dst_i     (wr_dst_i),
    .dst_hi_i  (wr_dst_hi_i),
    .data_i    (wr_data_i),
    .cst_i     (wr_const_i),
    .cur_lo_i  (cur_lo[wr_dst_i[IW]]),
    .pred_ok_i (pred_ok),
    .we_lo_o   (we_lo),
    .we_hi_o   (we_hi),
    .d_lo_o    (d_lo),
    .d_hi_o    (d_hi),
    .err_o     (wr_err_o)
  );

  a_r6_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> (we_lo == 2'b00 && we_hi == 2'b00));
  a_r3_pred_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pred_ok) |-> (we_lo == 2'b00));
  a_r2_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_lo) && $onehot0(we_hi));
  a_r7_const_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|we_lo) && mode == WM_CLO) |-> (d_lo[DW-1:CW] == {(DW-CW){wr_const_i[CW-1]}}));
  a_r8_const_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|we_lo) && mode == WM_CHI) |-> (d_lo[CW-1:0] == cur_lo[wr_dst_i[IW]]));
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (we_lo == 2'b00 && !wr_err_o));
endmodule

// File: tb/tb_rf_two_side.sv
module tb_rf_two_side;
  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [3:0][3:0]     rd_idx = '0;
  logic [3:0][31:0]    rd_data;
  logic [3:0][63:0]    rd_pair;
  logic                wr_en = 1'b0;
  logic [1:0]          wr_mode = '0;
  logic [4:0]          wr_dst = '0, wr_dst_hi = '0;
  logic [39:0]         wr_data = '0;
  logic [15:0]         wr_const = '0;
  logic [2:0]          pred_sel = '0;
  logic                pred_inv = 1'b0;
  logic                wr_err;
  int                  n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  rf_two_side dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .rd_pair_o(rd_pair), .wr_en_i(wr_en), .wr_mode_i(wr_mode), .wr_dst_i(wr_dst),
    .wr_dst_hi_i(wr_dst_hi), .wr_data_i(wr_data), .wr_const_i(wr_const),
    .pred_sel_i(pred_sel), .pred_inv_i(pred_inv), .wr_err_o(wr_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // side 0=A 1=B
  task automatic rd(input int side, input int idx, output logic [31:0] d, output logic [63:0] p);
    rd_idx[side*2] = 4'(idx);
    #0.5;
    d = rd_data[side*2];
    p = rd_pair[side*2];
  endtask

  task automatic wr(input logic [1:0] m, input logic [4:0] dst, input logic [4:0] dhi,
                    input logic [39:0] d, input logic [15:0] c,
                    input logic [2:0] ps, input logic pi);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = m; wr_dst = dst; wr_dst_hi = dhi;
    wr_data = d; wr_const = c; pred_sel = ps; pred_inv = pi;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] p;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++) begin
        rd(s, i, d, p);
        chk("R1 reset value", {32'b0, d}, 64'd0);
      end
  endtask

  task automatic t_word;
    logic [31:0] d; logic [63:0] p;
    @(negedge clk);
    rd_idx[0] = 4'd5;
    wr_en = 1'b1; wr_mode = 2'd0; wr_dst = 5'h05; wr_data = 40'h00DEADBEEF;
    pred_sel = 3'd0; pred_inv = 1'b0;
    #0.5;
    chk("R9 old value in write cycle", {32'b0, rd_data[0]}, 64'd0);
    @(posedge clk);
    #1 wr_en = 1'b0;
    rd(0, 5, d, p);
    chk("R2 A5 word write", {32'b0, d}, 64'hDEADBEEF);
    wr(2'd0, 5'h1C, 5'h00, 40'h0012345678, 16'h0, 3'd0, 1'b1);
    rd(1, 12, d, p);
    chk("R2 B12 word write", {32'b0, d}, 64'h12345678);
    rd(0, 12, d, p);
    chk("R2 A12 untouched", {32'b0, d}, 64'd0);
  endtask

  task automatic t_pred;
    logic [31:0] d; logic [63:0] p;
    wr(2'd0, 5'h07, 5'h0, 40'h11, 16'h0, 3'd3, 1'b0);  // B0==0 -> no write
    rd(0, 7, d, p);
    chk("R3 B0 zero blocks", {32'b0, d}, 64'd0);
    wr(2'd0, 5'h07, 5'h0, 40'h22, 16'h0, 3'd3, 1'b1);  // inverted -> write
    rd(0, 7, d, p);
    chk("R3 B0 zero inverted writes", {32'b0, d}, 64'h22);
    wr(2'd0, 5'h01, 5'h0, 40'h5, 16'h0, 3'd0, 1'b0);   // A1=5
    wr(2'd0, 5'h08, 5'h0, 40'h33, 16'h0, 3'd1, 1'b0);
    rd(0, 8, d, p);
    chk("R3 A1 nonzero writes", {32'b0, d}, 64'h33);
    wr(2'd0, 5'h08, 5'h0, 40'h44, 16'h0, 3'd1, 1'b1);
    rd(0, 8, d, p);
    chk("R3 A1 nonzero inverted blocks", {32'b0, d}, 64'h33);
    wr(2'd0, 5'h08, 5'h0, 40'h55, 16'h0, 3'd6, 1'b0);
    wr(2'd0, 5'h08, 5'h0, 40'h66, 16'h0, 3'd7, 1'b1);
    rd(0, 8, d, p);
    chk("R3 codes 6/7 never write", {32'b0, d}, 64'h33);
    wr(2'd0, 5'h11, 5'h0, 40'h1, 16'h0, 3'd0, 1'b0);   // B1=1
    wr(2'd0, 5'h09, 5'h0, 40'h77, 16'h0, 3'd4, 1'b0);
    rd(0, 9, d, p);
    chk("R3 B1 nonzero writes", {32'b0, d}, 64'h77);
    wr(2'd0, 5'h09, 5'h0, 40'h88, 16'h0, 3'd5, 1'b0);  // B2==0 blocks
    rd(0, 9, d, p);
    chk("R3 B2 zero blocks", {32'b0, d}, 64'h77);
  endtask

  task automatic t_pred_self;
    logic [31:0] d; logic [63:0] p;
    wr(2'd0, 5'h01, 5'h0, 40'h0, 16'h0, 3'd1, 1'b0);   // A1=5 -> commit 0
    rd(0, 1, d, p);
    chk("R4 self predicate uses old value", {32'b0, d}, 64'd0);
    wr(2'd0, 5'h01, 5'h0, 40'h9, 16'h0, 3'd1, 1'b0);   // A1=0 -> blocked
    rd(0, 1, d, p);
    chk("R4 self predicate blocks", {32'b0, d}, 64'd0);
  endtask

  task automatic t_pair;
    logic [31:0] d; logic [63:0] p;
    wr(2'd0, 5'h15, 5'h0, 40'hFFFFFFFF, 16'h0, 3'd0, 1'b0);  // B5 all ones
    wr(2'd1, 5'h14, 5'h15, 40'h8012345678, 16'h0, 3'd0, 1'b0);
    rd(1, 4, d, p);
    chk("R5 pair even word", {32'b0, d}, 64'h12345678);
    chk("R10 pair read negative", p, 64'hFFFFFF8012345678);
    rd(1, 5, d, p);
    chk("R5 pair odd upper cleared", {32'b0, d}, 64'h80);
    chk("R10 odd index pair zero", p, 64'd0);
    wr(2'd1, 5'h02, 5'h03, 40'h7F00000001, 16'h0, 3'd0, 1'b0);
    rd(0, 2, d, p);
    chk("R10 pair read positive", p, 64'h0000007F00000001);
  endtask

  task automatic t_pair_bad(input logic [4:0] lo, input logic [4:0] hi, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 2'd1; wr_dst = lo; wr_dst_hi = hi;
    wr_data = 40'hAA_BBBB_CCCC; pred_sel = 3'd0; pred_inv = 1'b0;
    #0.5;
    chk({"R6 err flag ", tag}, {63'b0, wr_err}, 64'd1);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic t_illegal;
    logic [31:0] d; logic [63:0] p;
    t_pair_bad(5'h03, 5'h04, "odd start");
    t_pair_bad(5'h06, 5'h17, "cross side");
    t_pair_bad(5'h06, 5'h09, "gap");
    rd(0, 3, d, p);  chk("R6 A3 kept", {32'b0, d}, 64'h7F);
    rd(0, 4, d, p);  chk("R6 A4 kept", {32'b0, d}, 64'd0);
    rd(0, 6, d, p);  chk("R6 A6 kept", {32'b0, d}, 64'd0);
    rd(1, 7, d, p);  chk("R6 B7 kept", {32'b0, d}, 64'd0);
    rd(0, 9, d, p);  chk("R6 A9 kept", {32'b0, d}, 64'h77);
    #0.5 chk("R6 err low when idle", {63'b0, wr_err}, 64'd0);
  endtask

  task automatic t_const;
    logic [31:0] d; logic [63:0] p;
    wr(2'd0, 5'h0A, 5'h0, 40'h87654321, 16'h0, 3'd0, 1'b0);
    wr(2'd2, 5'h0A, 5'h0, 40'h0, 16'hFABC, 3'd0, 1'b0);
    rd(0, 10, d, p);
    chk("R7 low load sign extends", {32'b0, d}, 64'hFFFFFABC);
    wr(2'd3, 5'h0A, 5'h0, 40'h0, 16'h1234, 3'd0, 1'b0);
    rd(0, 10, d, p);
    chk("R8 high load keeps low", {32'b0, d}, 64'h1234FABC);
    wr(2'd3, 5'h1B, 5'h0, 40'h0, 16'h1234, 3'd0, 1'b0);
    wr(2'd2, 5'h1B, 5'h0, 40'h0, 16'hFABC, 3'd0, 1'b0);
    rd(1, 11, d, p);
    chk("R7 low after high overwrites", {32'b0, d}, 64'hFFFFFABC);
    wr(2'd2, 5'h0B, 5'h0, 40'h0, 16'h7ABC, 3'd0, 1'b0);
    rd(0, 11, d, p);
    chk("R7 positive constant", {32'b0, d}, 64'h00007ABC);
  endtask

  task automatic t_idle;
    logic [31:0] d; logic [63:0] p;
    @(negedge clk);
    wr_en = 1'b0; wr_mode = 2'd0; wr_dst = 5'h05; wr_data = 40'h0;
    repeat (3) @(posedge clk);
    #1 rd(0, 5, d, p);
    chk("R11 idle keeps A5", {32'b0, d}, 64'hDEADBEEF);
  endtask

  initial begin
    #300000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk) rst_n = 1'b1;
    t_word;
    t_pred;
    t_pred_self;
    t_pair;
    t_illegal;
    t_const;
    t_idle;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule